// File: doc/BRIEF.md
# USB Bus Suspend Detector and Power-Down Sequencer

This block watches the decoded line state of a full-speed USB bus and, once the line has stayed idle past a threshold counted in millisecond ticks, latches a suspend-detected status flag. An enable bit gates that flag onto an interrupt line. A live bus-idle status bit lets firmware see whether the bus is still quiet before it commits to power-down.

Firmware carries out entry into suspend through a small register port. It first clears a clock-run control bit, which drops the clock enable at once. It then writes a go-to-sleep bit high and then low. The falling edge of that bit starts a delay of a fixed number of millisecond ticks. When the delay ends, the SUSPEND output rises and the clock enable is held low. Any bus activity during the delay or during suspend returns the block to the awake state, sets clock-run again and restores the clock enable.

Top module: `usb_suspend_ctl`

## Requirements
- R1: After reset, irq_o and suspend_o are 0, clk_en_o is 1, the status and enable bits read 0, the clock-run bit reads 1 and the go bit reads 0.
- R2: The suspend flag (address 0, bit 0) is set on the tick that completes IDLE_MS+1 consecutive idle ticks. Any cycle in which line_idle is 0 restarts that count.
- R3: The suspend flag is set at most once per idle period. After it is cleared it stays 0 while the bus remains idle.
- R4: Writing 1 to address 0 bit 0 clears the suspend flag. Writing 0 to that bit has no effect. If the flag is set and a clear is written in the same cycle, the flag ends up set.
- R5: irq_o is 1 exactly when the suspend flag is 1 and the interrupt enable (address 1, bit 0) is 1.
- R6: The bus status (address 0, bit 1) reads 1 only while line_idle is 1 and the idle threshold of R2 has been reached. It reads 0 from the first non-idle cycle, without latching.
- R7: The clock-run bit is address 2, bit 0. While it is 0, clk_en_o is 0.
- R8: The go bit is address 3, bit 0. Writing 0 to it while it holds 1 starts entry into suspend, but only when clock-run is 0. Otherwise the falling edge has no effect on suspend_o.
- R9: suspend_o rises SUSP_DLY_MS ticks after entry starts, provided the bus stays idle, and clk_en_o is 0 while suspend_o is 1.
- R10: A non-idle cycle during the delay or during suspend drops suspend_o on the next cycle, sets clock-run to 1 and restores clk_en_o to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_idle | input | 1 | Decoded line state, 1 when the bus is idle |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Suspend interrupt request |
| suspend_o | output | 1 | Suspended indication |
| clk_en_o | output | 1 | Internal clock enable |

## Verification
The bench builds the block with its defaults, IDLE_MS = 3 and SUSP_DLY_MS = 2, and drives tick_1ms once every four clocks. Detection and the power-down delay therefore each finish within a couple of dozen cycles. This short time scale puts idle runs broken one tick short of the threshold, a clear write that lands on the exact set cycle, and wake-ups from both the delay phase and the asleep phase all within a short run. A behavioural model in the bench compares every output and the read data on every clock.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
   typedef enum logic [1:0] {
      PS_AWAKE  = 2'd0,
      PS_DELAY  = 2'd1,
      PS_ASLEEP = 2'd2
   } pwr_state_t;

   localparam logic [1:0] ADR_STATUS = 2'd0;
   localparam logic [1:0] ADR_ENABLE = 2'd1;
   localparam logic [1:0] ADR_CLKCFG = 2'd2;
   localparam logic [1:0] ADR_MODE   = 2'd3;

   localparam int BIT_SUSP_FLAG = 0;
   localparam int BIT_BUS_IDLE  = 1;
   localparam int BIT_CTRL      = 0;
endpackage

// File: rtl/susp_idle_timer.sv
module susp_idle_timer #(
   parameter int IDLE_MS = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_idle,
   input  logic tick,
   output logic set_evt_o,
   output logic bus_sts_o
);
   localparam int LIMIT = IDLE_MS + 1;
   localparam int CW    = $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM_V  = CW'(LIMIT);
   localparam logic [CW-1:0] PRE_V  = CW'(LIMIT - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!line_idle) begin
         cnt_q <= '0;
      end else if (tick && (cnt_q != LIM_V)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign set_evt_o = line_idle && tick && (cnt_q == PRE_V);
   assign bus_sts_o = line_idle && (cnt_q == LIM_V);
endmodule

// File: rtl/susp_regs.sv
module susp_regs
   import usb_susp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              set_evt,
   input  logic              bus_sts,
   input  logic              wake,
   output logic              sts_o,
   output logic              ie_o,
   output logic              run_o,
   output logic              go_fall_o,
   output logic [DATA_W-1:0] rdata
);
   logic sts_q, ie_q, run_q, go_q;
   logic clr_req;

   assign clr_req   = wr && (addr == ADR_STATUS) && wdata[BIT_SUSP_FLAG];
   assign go_fall_o = wr && (addr == ADR_MODE) && !wdata[BIT_CTRL] && go_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= 1'b0;
         ie_q  <= 1'b0;
         run_q <= 1'b1;
         go_q  <= 1'b0;
      end else begin
         if (set_evt)      sts_q <= 1'b1;
         else if (clr_req) sts_q <= 1'b0;
         if (wr && (addr == ADR_ENABLE)) ie_q <= wdata[BIT_CTRL];
         if (wake)                            run_q <= 1'b1;
         else if (wr && (addr == ADR_CLKCFG)) run_q <= wdata[BIT_CTRL];
         if (wr && (addr == ADR_MODE)) go_q <= wdata[BIT_CTRL];
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADR_STATUS: begin
            rdata[BIT_SUSP_FLAG] = sts_q;
            rdata[BIT_BUS_IDLE]  = bus_sts;
         end
         ADR_ENABLE: rdata[BIT_CTRL] = ie_q;
         ADR_CLKCFG: rdata[BIT_CTRL] = run_q;
         default:    rdata[BIT_CTRL] = go_q;
      endcase
   end

   assign sts_o = sts_q;
   assign ie_o  = ie_q;
   assign run_o = run_q;
endmodule

// File: rtl/susp_pwr_fsm.sv
module susp_pwr_fsm
   import usb_susp_pkg::*;
#(
   parameter int SUSP_DLY_MS = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_idle,
   input  logic       tick,
   input  logic       go_fall,
   input  logic       clk_run,
   output pwr_state_t state_o,
   output logic       wake_o
);
   localparam int DW = (SUSP_DLY_MS < 2) ? 1 : $clog2(SUSP_DLY_MS);
   localparam logic [DW-1:0] LAST_V = DW'(SUSP_DLY_MS - 1);

   pwr_state_t    st_q;
   logic [DW-1:0] dcnt_q;

   assign wake_o = (st_q != PS_AWAKE) && !line_idle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_AWAKE;
         dcnt_q <= '0;
      end else begin
         unique case (st_q)
            PS_AWAKE: begin
               if (go_fall && !clk_run) begin
                  st_q   <= PS_DELAY;
                  dcnt_q <= '0;
               end
            end
            PS_DELAY: begin
               if (!line_idle) begin
                  st_q <= PS_AWAKE;
               end else if (tick) begin
                  if (dcnt_q == LAST_V) st_q <= PS_ASLEEP;
                  else                  dcnt_q <= dcnt_q + 1'b1;
               end
            end
            default: begin
               if (!line_idle) st_q <= PS_AWAKE;
            end
         endcase
      end
   end

   assign state_o = st_q;
endmodule

// File: rtl/usb_suspend_ctl.sv
module usb_suspend_ctl
   import usb_susp_pkg::*;
#(
   parameter int IDLE_MS     = 3,
   parameter int SUSP_DLY_MS = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_idle,
   input  logic              tick_1ms,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_o,
   output logic              suspend_o,
   output logic              clk_en_o
);
   generate
      if (IDLE_MS < 1)     begin : g_bad_idle  $error("IDLE_MS must be at least 1");     end
      if (SUSP_DLY_MS < 1) begin : g_bad_delay $error("SUSP_DLY_MS must be at least 1"); end
      if (DATA_W < 2)      begin : g_bad_width $error("DATA_W must be at least 2");      end
   endgenerate

   logic       set_evt, bus_sts, sts, ie, run, go_fall, wake;
   pwr_state_t pstate;

   susp_idle_timer #(.IDLE_MS(IDLE_MS)) u_timer (
      .clk(clk), .rst_n(rst_n), .line_idle(line_idle), .tick(tick_1ms),
      .set_evt_o(set_evt), .bus_sts_o(bus_sts)
   );

   susp_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .set_evt(set_evt), .bus_sts(bus_sts), .wake(wake),
      .sts_o(sts), .ie_o(ie), .run_o(run), .go_fall_o(go_fall), .rdata(reg_rdata)
   );

   susp_pwr_fsm #(.SUSP_DLY_MS(SUSP_DLY_MS)) u_fsm (
      .clk(clk), .rst_n(rst_n), .line_idle(line_idle), .tick(tick_1ms),
      .go_fall(go_fall), .clk_run(run), .state_o(pstate), .wake_o(wake)
   );

   assign irq_o     = sts & ie;
   assign suspend_o = (pstate == PS_ASLEEP);
   assign clk_en_o  = run & (pstate != PS_ASLEEP);
endmodule

// File: rtl/usb_suspend_ctl_checker.sv
module usb_suspend_ctl_checker
   import usb_susp_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       line_idle,
   input logic       suspend_o,
   input logic       clk_en_o,
   input logic       sts,
   input logic       bus_sts,
   input logic       run,
   input pwr_state_t pstate
);
   p_flag_rises_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts) |-> $past(line_idle));

   p_bus_sts_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sts |-> line_idle);

   p_no_clock_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_o |-> !clk_en_o);

   p_asleep_via_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspend_o) |-> $past(pstate) == PS_DELAY);

   p_entry_needs_run_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pstate == PS_DELAY && $past(pstate) == PS_AWAKE) |-> !$past(run));

   p_activity_wakes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_idle && pstate != PS_AWAKE) |=> (!suspend_o && run));
endmodule

bind usb_suspend_ctl usb_suspend_ctl_checker u_chk (
   .clk(clk), .rst_n(rst_n), .line_idle(line_idle), .suspend_o(suspend_o),
   .clk_en_o(clk_en_o), .sts(sts), .bus_sts(bus_sts), .run(run), .pstate(pstate)
);

// File: tb/usb_suspend_ctl_tb_top.sv
module usb_suspend_ctl_tb_top;
   localparam int IDLE_MS = 3;
   localparam int DLY_MS  = 2;
   localparam int LIM     = IDLE_MS + 1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_idle = 1'b0;
   logic       tick_1ms = 1'b0;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       irq_o, suspend_o, clk_en_o;

   always #10 clk = ~clk;

   usb_suspend_ctl #(.IDLE_MS(IDLE_MS), .SUSP_DLY_MS(DLY_MS), .DATA_W(8)) dut_i (
      .clk(clk), .rst_n(rst_n), .line_idle(line_idle), .tick_1ms(tick_1ms),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq_o(irq_o), .suspend_o(suspend_o), .clk_en_o(clk_en_o)
   );

   int checks = 0;
   int fails  = 0;
   int tcnt   = 0;
   bit done   = 0;

   // behavioural reference state
   int m_cnt = 0, m_dcnt = 0, m_state = 0;
   bit m_sus = 0, m_ie = 0, m_run = 1, m_go = 0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int model_rdata(input int a);
      case (a)
         0: return ((line_idle && m_cnt == LIM) ? 2 : 0) + (m_sus ? 1 : 0);
         1: return m_ie ? 1 : 0;
         2: return m_run ? 1 : 0;
         default: return m_go ? 1 : 0;
      endcase
   endfunction

   task automatic compare_all();
      string rtag;
      check(irq_o === (m_sus && m_ie), "R5 irq", irq_o, m_sus && m_ie);
      check(suspend_o === (m_state == 2), "R9 suspend", suspend_o, m_state == 2);
      check(clk_en_o === (m_run && m_state != 2), "R7 clk_en", clk_en_o, m_run && m_state != 2);
      case (reg_addr)
         2'd0: rtag = "R2 status read";
         2'd1: rtag = "R5 enable read";
         2'd2: rtag = "R7 clkrun read";
         default: rtag = "R8 go read";
      endcase
      check(int'(reg_rdata) == model_rdata(int'(reg_addr)), rtag, reg_rdata, model_rdata(int'(reg_addr)));
   endtask

   function automatic bit set_next();
      return line_idle && tick_1ms && (m_cnt == LIM - 1);
   endfunction

   // one clock: drive inputs, update the model at the edge, compare away from it
   task automatic step(input bit idle, input bit wr, input logic [1:0] a, input logic [7:0] wd);
      bit set, clr, fall, wake;
      line_idle = idle; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      tick_1ms = (tcnt % 4 == 3);
      tcnt++;
      @(posedge clk);
      set  = set_next();
      clr  = wr && a == 2'd0 && wd[0];
      fall = wr && a == 2'd3 && !wd[0] && m_go;
      wake = (m_state != 0) && !idle;
      if (set) m_sus = 1; else if (clr) m_sus = 0;
      if (wr && a == 2'd1) m_ie = wd[0];
      if (wake) m_run = 1; else if (wr && a == 2'd2) m_run = wd[0];
      if (wr && a == 2'd3) m_go = wd[0];
      case (m_state)
         0: if (fall && !m_run_prev()) begin m_state = 1; m_dcnt = 0; end
         1: if (!idle) m_state = 0;
            else if (tick_1ms) begin
               if (m_dcnt == DLY_MS - 1) m_state = 2; else m_dcnt++;
            end
         default: if (!idle) m_state = 0;
      endcase
      if (!idle) m_cnt = 0;
      else if (tick_1ms && m_cnt < LIM) m_cnt++;
      save_run();
      @(negedge clk);
      line_idle = idle; reg_wr = 1'b0;
      compare_all();
   endtask

   // clock-run value seen by the entry decision is the pre-edge one
   bit run_before = 1;
   function automatic bit m_run_prev(); return run_before; endfunction
   task automatic save_run(); run_before = m_run; endtask

   task automatic idle_for(input int n, input logic [1:0] a);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, a, 8'd0);
   endtask

   task automatic busy_for(input int n, input logic [1:0] a);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, a, 8'd0);
   endtask

   task automatic wr_reg(input bit idle, input logic [1:0] a, input logic [7:0] d);
      step(idle, 1'b1, a, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check(irq_o == 0, "R1 irq reset", irq_o, 0);
      check(suspend_o == 0, "R1 suspend reset", suspend_o, 0);
      check(clk_en_o == 1, "R1 clk_en reset", clk_en_o, 1);
      reg_addr = 2'd2; #1;
      check(reg_rdata == 8'd1, "R1 clkrun reset", reg_rdata, 1);
      reg_addr = 2'd3; #1;
      check(reg_rdata == 8'd0, "R1 go reset", reg_rdata, 0);

      busy_for(4, 2'd0);
      wr_reg(1'b0, 2'd1, 8'd1);                 // enable interrupt
      // R2: short idle, broken before threshold
      idle_for(12, 2'd0);
      busy_for(1, 2'd0);
      check(reg_rdata[0] == 0, "R2 no flag after short idle", reg_rdata[0], 0);
      idle_for(24, 2'd0);
      check(reg_rdata[0] == 1, "R2 flag after long idle", reg_rdata[0], 1);
      check(irq_o == 1, "R5 irq with enable", irq_o, 1);
      check(reg_rdata[1] == 1, "R6 bus status idle", reg_rdata[1], 1);
      // R4: writing 0 does nothing, writing 1 clears
      wr_reg(1'b1, 2'd0, 8'd0);
      check(reg_rdata[0] == 1, "R4 zero write ignored", reg_rdata[0], 1);
      wr_reg(1'b1, 2'd0, 8'd1);
      // R3: remains clear while idle continues
      idle_for(30, 2'd0);
      check(reg_rdata[0] == 0, "R3 no re-set same idle period", reg_rdata[0], 0);
      // R6: live drop on activity
      busy_for(1, 2'd0);
      check(reg_rdata[1] == 0, "R6 bus status drops", reg_rdata[1], 0);
      // R5: disable gates irq
      wr_reg(1'b0, 2'd1, 8'd0);
      idle_for(24, 2'd1);
      check(irq_o == 0, "R5 irq masked", irq_o, 0);
      wr_reg(1'b1, 2'd0, 8'd1);
      // R4: clear written on the exact set cycle
      busy_for(2, 2'd0);
      for (int i = 0; i < 40; i++) begin
         line_idle = 1'b1; tick_1ms = (tcnt % 4 == 3);
         if (set_next()) begin
            wr_reg(1'b1, 2'd0, 8'd1);
            reg_addr = 2'd0; #1;
            check(reg_rdata[0] == 1, "R4 set wins over clear", reg_rdata[0], 1);
         end else step(1'b1, 1'b0, 2'd0, 8'd0);
      end
      // R8: falling go with clock-run still 1 has no effect
      wr_reg(1'b1, 2'd3, 8'd1);
      wr_reg(1'b1, 2'd3, 8'd0);
      idle_for(20, 2'd3);
      check(suspend_o == 0, "R8 entry blocked by clock-run", suspend_o, 0);
      // R7: clearing clock-run drops clk_en
      wr_reg(1'b1, 2'd2, 8'd0);
      check(clk_en_o == 0, "R7 clk_en low", clk_en_o, 0);
      // R9: entry then delayed suspend
      wr_reg(1'b1, 2'd3, 8'd1);
      wr_reg(1'b1, 2'd3, 8'd0);
      check(suspend_o == 0, "R9 not yet asleep", suspend_o, 0);
      idle_for(12, 2'd2);
      check(suspend_o == 1, "R9 asleep after delay", suspend_o, 1);
      // R10: activity wakes from suspend
      busy_for(1, 2'd2);
      check(suspend_o == 0, "R10 wake suspend low", suspend_o, 0);
      check(clk_en_o == 1, "R10 wake clk_en", clk_en_o, 1);
      check(reg_rdata == 8'd1, "R10 clock-run set", reg_rdata, 1);
      // R10: activity during delay aborts entry
      idle_for(4, 2'd2);
      wr_reg(1'b1, 2'd2, 8'd0);
      wr_reg(1'b1, 2'd3, 8'd1);
      wr_reg(1'b1, 2'd3, 8'd0);
      idle_for(2, 2'd2);
      busy_for(1, 2'd2);
      idle_for(16, 2'd2);
      check(suspend_o == 0, "R10 abort during delay", suspend_o, 0);
      check(clk_en_o == 1, "R10 clk_en after abort", clk_en_o, 1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule